// File: doc/BRIEF.md
# Configuration Image CRC Validator

This block validates a configuration image stored as 16-bit words in a word-addressed serial memory. On a check request it reads the image from address 0 upward. It runs every byte through a bit-serial CRC-8 engine and compares the result with the checksum byte held in the image's final word. The short image size is tried first. If that comparison fails, the whole image is read again at the long size. When the block finishes it reports which size it accepted, whether the checksum matched, and the revision byte found in the final word.

The CRC is reflected, with generator x^8+x^7+x^6+x^4+x^2+1, so each step shifts right and XORs 0xAB when a one falls out. The seed is 0xFF. Each word except the last feeds its low byte and then its high byte. The last word feeds only its low byte. The register is then inverted, and the result must equal the high byte of that last word. Each byte takes eight clock cycles.

The same block also programs the memory. It raises a write-enable control and waits a settle time. It then writes every word, taking each from a data input that is indexed by the current address, and leaves a gap after each write. Finally it drops write-enable and waits the settle time again. The states are ST_IDLE, ST_CHK_INIT, ST_RD_ISSUE, ST_RD_WAIT, ST_LO_GO, ST_LO_RUN, ST_HI_GO, ST_HI_RUN, ST_JUDGE, ST_WR_SET, ST_WR_SETTLE, ST_WR_LOAD, ST_WR_PULSE, ST_WR_GAP, ST_WR_CLR, ST_WR_TAIL and ST_FINISH.

The transitions are as follows:
- A check start in ST_IDLE goes to ST_CHK_INIT.
- ST_CHK_INIT goes to ST_RD_ISSUE, then to ST_RD_WAIT. When the read data returns, the block moves to ST_LO_GO and then ST_LO_RUN.
- When the engine goes idle in ST_LO_RUN, the block goes to ST_JUDGE for the last word and to ST_HI_GO for any other word.
- ST_HI_GO leads to ST_HI_RUN, which returns to ST_RD_ISSUE with the next address.
- ST_JUDGE goes to ST_FINISH on a match or after the long pass. After a failed short pass it goes back to ST_CHK_INIT.
- A write start goes through ST_WR_SET and ST_WR_SETTLE. Each word then takes ST_WR_LOAD, ST_WR_PULSE and ST_WR_GAP. After the last word the block passes through ST_WR_CLR and ST_WR_TAIL.
- ST_FINISH always returns to ST_IDLE.

Top module: `eeprom_image_checker`

## Requirements
- R1: After reset the block is idle: busy, done, mem_rd, mem_we and wr_enable are 0, and size_long, crc_ok and revision are 0.
- R2: The checksum is computed as follows. The register starts at 0xFF and is updated byte by byte, reflected, shifting right and XORing 0xAB when bit 0 is 1. For each word before the last, bits 7:0 are processed and then bits 15:8. For the last word only bits 7:0 are processed. The register is then XORed with 0xFF and compared with bits 15:8 of the last word.
- R3: The first pass covers SHORT_WORDS words. If it matches, the result is size_long=0 and crc_ok=1, and exactly SHORT_WORDS reads are issued.
- R4: If the short pass fails, the image is read again from address 0 over LONG_WORDS words. If the long pass matches, the result is size_long=1 and crc_ok=1, after SHORT_WORDS+LONG_WORDS reads in total.
- R5: If both passes fail, the result is crc_ok=0 and size_long=1.
- R6: revision equals bits 7:0 of the last word of the final pass, whether or not the checksum matched.
- R7: Read addresses run from 0 upward by one. Data is taken from mem_rdata when mem_rvalid is 1, one cycle after mem_rd. mem_rd is never high in two consecutive cycles, and it is never high together with mem_we.
- R8: The write sequence proceeds in this order. wr_enable rises. The first write follows at least SETTLE_CYC cycles later. Consecutive writes are at least GAP_CYC cycles apart. wr_enable falls at least GAP_CYC cycles after the last write. done follows at least SETTLE_CYC cycles after that fall. Each interval is at most 4 cycles longer than its minimum.
- R9: Each write stores, at mem_addr, the wr_data value presented for that address. Addresses run from 0 upward by one. mem_we is only ever high while wr_enable is high.
- R10: wr_long, sampled at the write start, selects LONG_WORDS words when it is 1 and SHORT_WORDS words when it is 0.
- R11: A start of either kind is ignored while busy is 1. The results of a check are held through any later write sequence.
- R12: done is a one-cycle pulse at the end of each sequence. If both starts are high in ST_IDLE, the check is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_chk | input | 1 | Request an image check |
| start_wr | input | 1 | Request an image write |
| wr_long | input | 1 | Write size select (1 = long), sampled at write start |
| wr_data | input | 16 | Word to write at the current mem_addr |
| mem_rvalid | input | 1 | Read data valid, one cycle after mem_rd |
| mem_rdata | input | 16 | Read data |
| mem_rd | output | 1 | Read strobe |
| mem_we | output | 1 | Write strobe |
| mem_addr | output | ADDR_W | Word address (8 bits by default) |
| mem_wdata | output | 16 | Write data |
| wr_enable | output | 1 | Memory write-enable control |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| size_long | output | 1 | Accepted size was the long one |
| crc_ok | output | 1 | Checksum matched |
| revision | output | 8 | Low byte of the last word read |

## Verification
The check is exercised with four image patterns:
- A short image sealed with a correct checksum shows that the first pass stops after SHORT_WORDS reads.
- A uniform all-ones image sealed at the short size exercises a data pattern with every bit set.
- A long image whose short-size checksum byte is deliberately wrong separates the retry path from the short path, by the read count and by size_long.
- An image in which both checksum bytes are wrong shows that the revision is still reported while crc_ok drops.

Short and long writes are timed against the settle and gap windows and compared word by word. Starts of each kind are injected during the other sequence to show they are ignored.

// File: rtl/eeprom_image_pkg.sv
package eeprom_image_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CHK_INIT,
        ST_RD_ISSUE,
        ST_RD_WAIT,
        ST_LO_GO,
        ST_LO_RUN,
        ST_HI_GO,
        ST_HI_RUN,
        ST_JUDGE,
        ST_WR_SET,
        ST_WR_SETTLE,
        ST_WR_LOAD,
        ST_WR_PULSE,
        ST_WR_GAP,
        ST_WR_CLR,
        ST_WR_TAIL,
        ST_FINISH
    } seq_state_t;

    localparam logic [7:0] CRC_POLY_REFL = 8'hAB;
    localparam logic [7:0] CRC_SEED      = 8'hFF;
    localparam logic [7:0] CRC_XOR_OUT   = 8'hFF;
    localparam int         CRC_BITS      = 8;

endpackage

// File: rtl/crc8_bitserial.sv
module crc8_bitserial
    import eeprom_image_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       start,
    input  logic [7:0] data,
    output logic [7:0] crc,
    output logic       busy
);

    localparam int CNT_W = $clog2(CRC_BITS);

    logic [7:0]       crc_q;
    logic [CNT_W-1:0] left_q;

    function automatic logic [7:0] shift_one(input logic [7:0] v);
        return v[0] ? ((v >> 1) ^ CRC_POLY_REFL) : (v >> 1);
    endfunction

    // First bit is folded into the start cycle, so a byte occupies CRC_BITS cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q  <= CRC_SEED;
            left_q <= '0;
        end else if (init) begin
            crc_q  <= CRC_SEED;
            left_q <= '0;
        end else if (start) begin
            crc_q  <= shift_one(crc_q ^ data);
            left_q <= CNT_W'(CRC_BITS - 1);
        end else if (left_q != '0) begin
            crc_q  <= shift_one(crc_q);
            left_q <= left_q - 1'b1;
        end
    end

    assign crc  = crc_q;
    assign busy = (left_q != '0);

endmodule

// File: rtl/wait_timer.sv
module wait_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] load,
    output logic             zero
);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start) begin
            cnt_q <= load;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/eeprom_image_checker.sv
module eeprom_image_checker
    import eeprom_image_pkg::*;
#(
    parameter int SHORT_WORDS = 64,
    parameter int LONG_WORDS  = 220,
    parameter int SETTLE_CYC  = 125_000_000,
    parameter int GAP_CYC     = 5_000_000
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start_chk,
    input  logic                           start_wr,
    input  logic                           wr_long,
    input  logic [15:0]                    wr_data,
    input  logic                           mem_rvalid,
    input  logic [15:0]                    mem_rdata,
    output logic                           mem_rd,
    output logic                           mem_we,
    output logic [$clog2(LONG_WORDS)-1:0]  mem_addr,
    output logic [15:0]                    mem_wdata,
    output logic                           wr_enable,
    output logic                           busy,
    output logic                           done,
    output logic                           size_long,
    output logic                           crc_ok,
    output logic [7:0]                     revision
);

    localparam int ADDR_W  = $clog2(LONG_WORDS);
    localparam int TMR_MAX = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam logic [ADDR_W-1:0] LAST_SHORT = ADDR_W'(SHORT_WORDS - 1);
    localparam logic [ADDR_W-1:0] LAST_LONG  = ADDR_W'(LONG_WORDS - 1);

    seq_state_t state_q, state_d;

    logic [ADDR_W-1:0] idx_q;
    logic [15:0]       word_q;
    logic [15:0]       wdata_q;
    logic              long_q;
    logic              wr_long_q;
    logic              res_long_q;
    logic              res_ok_q;
    logic [7:0]        res_rev_q;

    logic              eng_init, eng_start, eng_busy;
    logic [7:0]        eng_byte, eng_crc;
    logic              tmr_start, tmr_zero;
    logic [TMR_W-1:0]  tmr_load;

    logic              last_rd, last_wr, crc_match;

    assign last_rd   = (idx_q == (long_q ? LAST_LONG : LAST_SHORT));
    assign last_wr   = (idx_q == (wr_long_q ? LAST_LONG : LAST_SHORT));
    assign crc_match = ((eng_crc ^ CRC_XOR_OUT) == word_q[15:8]);

    crc8_bitserial u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (eng_init),
        .start (eng_start),
        .data  (eng_byte),
        .crc   (eng_crc),
        .busy  (eng_busy)
    );

    wait_timer #(.WIDTH(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .load  (tmr_load),
        .zero  (tmr_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_chk)     state_d = ST_CHK_INIT;
                else if (start_wr) state_d = ST_WR_SET;
            end
            ST_CHK_INIT:  state_d = ST_RD_ISSUE;
            ST_RD_ISSUE:  state_d = ST_RD_WAIT;
            ST_RD_WAIT:   if (mem_rvalid) state_d = ST_LO_GO;
            ST_LO_GO:     state_d = ST_LO_RUN;
            ST_LO_RUN:    if (!eng_busy) state_d = last_rd ? ST_JUDGE : ST_HI_GO;
            ST_HI_GO:     state_d = ST_HI_RUN;
            ST_HI_RUN:    if (!eng_busy) state_d = ST_RD_ISSUE;
            ST_JUDGE:     state_d = (crc_match || long_q) ? ST_FINISH : ST_CHK_INIT;
            ST_WR_SET:    state_d = ST_WR_SETTLE;
            ST_WR_SETTLE: if (tmr_zero) state_d = ST_WR_LOAD;
            ST_WR_LOAD:   state_d = ST_WR_PULSE;
            ST_WR_PULSE:  state_d = ST_WR_GAP;
            ST_WR_GAP:    if (tmr_zero) state_d = last_wr ? ST_WR_CLR : ST_WR_LOAD;
            ST_WR_CLR:    state_d = ST_WR_TAIL;
            ST_WR_TAIL:   if (tmr_zero) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        mem_rd    = 1'b0;
        mem_we    = 1'b0;
        wr_enable = 1'b0;
        done      = 1'b0;
        eng_init  = 1'b0;
        eng_start = 1'b0;
        eng_byte  = word_q[7:0];
        tmr_start = 1'b0;
        tmr_load  = TMR_W'(SETTLE_CYC);
        unique case (state_q)
            ST_CHK_INIT:  eng_init = 1'b1;
            ST_RD_ISSUE:  mem_rd = 1'b1;
            ST_LO_GO:     eng_start = 1'b1;
            ST_HI_GO: begin
                eng_start = 1'b1;
                eng_byte  = word_q[15:8];
            end
            ST_WR_SET:    tmr_start = 1'b1;
            ST_WR_SETTLE: wr_enable = 1'b1;
            ST_WR_LOAD:   wr_enable = 1'b1;
            ST_WR_PULSE: begin
                wr_enable = 1'b1;
                mem_we    = 1'b1;
                tmr_start = 1'b1;
                tmr_load  = TMR_W'(GAP_CYC);
            end
            ST_WR_GAP:    wr_enable = 1'b1;
            ST_WR_CLR:    tmr_start = 1'b1;
            ST_FINISH:    done = 1'b1;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            word_q     <= '0;
            wdata_q    <= '0;
            long_q     <= 1'b0;
            wr_long_q  <= 1'b0;
            res_long_q <= 1'b0;
            res_ok_q   <= 1'b0;
            res_rev_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    idx_q <= '0;
                    if (start_chk)     long_q    <= 1'b0;
                    else if (start_wr) wr_long_q <= wr_long;
                end
                ST_CHK_INIT: idx_q <= '0;
                ST_RD_WAIT:  if (mem_rvalid) word_q <= mem_rdata;
                ST_HI_RUN:   if (!eng_busy) idx_q <= idx_q + 1'b1;
                ST_JUDGE: begin
                    if (crc_match || long_q) begin
                        res_long_q <= long_q;
                        res_ok_q   <= crc_match;
                        res_rev_q  <= word_q[7:0];
                    end else begin
                        long_q <= 1'b1;
                    end
                end
                ST_WR_LOAD: wdata_q <= wr_data;
                ST_WR_GAP:  if (tmr_zero && !last_wr) idx_q <= idx_q + 1'b1;
                default: ;
            endcase
        end
    end

    assign mem_addr  = idx_q;
    assign mem_wdata = wdata_q;
    assign busy      = (state_q != ST_IDLE);
    assign size_long = res_long_q;
    assign crc_ok    = res_ok_q;
    assign revision  = res_rev_q;

endmodule

// File: rtl/image_check_props.sv
module image_check_props (
    input logic clk,
    input logic rst_n,
    input logic mem_rd,
    input logic mem_we,
    input logic wr_enable,
    input logic busy,
    input logic done
);

    assert_rd_we_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_we));

    assert_rd_spaced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_we_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_enable);

    assert_we_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_enable_drop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_enable) |-> !mem_we);

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_idle_no_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_we && !wr_enable));

endmodule

bind eeprom_image_checker image_check_props u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_we    (mem_we),
    .wr_enable (wr_enable),
    .busy      (busy),
    .done      (done)
);

// File: tb/eeprom_image_checker_bench.sv
`timescale 1ns/1ps
module eeprom_image_checker_bench;

    localparam int SW = 64;
    localparam int LW = 220;
    localparam int SET = 20;
    localparam int GAP = 6;
    localparam int AW = $clog2(LW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_chk = 1'b0, start_wr = 1'b0, wr_long = 1'b0;
    logic [15:0] wr_data;
    logic mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic mem_rd, mem_we, wr_enable, busy, done, size_long, crc_ok;
    logic [AW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [7:0] revision;

    logic [15:0] img  [0:255];
    logic [15:0] wmem [0:255];

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    eeprom_image_checker #(.SHORT_WORDS(SW), .LONG_WORDS(LW), .SETTLE_CYC(SET), .GAP_CYC(GAP))
    u_eeprom_image_checker (
        .clk(clk), .rst_n(rst_n), .start_chk(start_chk), .start_wr(start_wr),
        .wr_long(wr_long), .wr_data(wr_data), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .wr_enable(wr_enable), .busy(busy), .done(done), .size_long(size_long),
        .crc_ok(crc_ok), .revision(revision)
    );

    assign wr_data = img[mem_addr];

    // Memory model: one-cycle read latency
    always @(posedge clk) begin
        mem_rvalid <= mem_rd;
        if (mem_rd) mem_rdata <= img[mem_addr];
        if (mem_we) wmem[mem_addr] <= mem_wdata;
    end

    // Monitor, sampled away from the active edge
    int cyc = 0, rd_cnt = 0, wr_cnt = 0, addr_err = 0, rd_addr_err = 0, done_cnt = 0, pulse_err = 0;
    int t_rise = 0, t_fall = 0, t_first = 0, t_last = 0, t_done = 0, gap_min = 0, gap_max = 0;
    logic en_prev = 1'b0, done_prev = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (mem_rd) begin
            if (int'(mem_addr) != (rd_cnt < SW ? rd_cnt : rd_cnt - SW)) rd_addr_err++;
            rd_cnt++;
        end
        if (wr_enable && !en_prev) t_rise = cyc;
        if (!wr_enable && en_prev) t_fall = cyc;
        if (mem_we) begin
            if (wr_cnt == 0) t_first = cyc;
            else begin
                if (cyc - t_last < gap_min) gap_min = cyc - t_last;
                if (cyc - t_last > gap_max) gap_max = cyc - t_last;
            end
            if (int'(mem_addr) != wr_cnt) addr_err++;
            t_last = cyc;
            wr_cnt++;
        end
        if (done) begin
            t_done = cyc;
            done_cnt++;
            if (done_prev) pulse_err++;
        end
        en_prev = wr_enable;
        done_prev = done;
    end

    task automatic clr_mon();
        rd_cnt = 0; wr_cnt = 0; addr_err = 0; rd_addr_err = 0; done_cnt = 0; pulse_err = 0;
        gap_min = 1 << 30; gap_max = 0; t_rise = 0; t_fall = 0;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input int act, input int lo);
        n_chk++;
        if (act < lo || act > lo + 4) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, lo + 4);
        end
    endtask

    // Reference checksum computed in the non-reflected domain
    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [7:0] fwd_byte(input logic [7:0] n, input logic [7:0] b);
        logic [7:0] x;
        x = n ^ rev8(b);
        for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'hD5) : (x << 1);
        return x;
    endfunction

    function automatic logic [7:0] model_crc(input int words);
        logic [7:0] n;
        n = 8'hFF;
        for (int w = 0; w < words - 1; w++) begin
            n = fwd_byte(n, img[w][7:0]);
            n = fwd_byte(n, img[w][15:8]);
        end
        n = fwd_byte(n, img[words-1][7:0]);
        return rev8(n) ^ 8'hFF;
    endfunction

    task automatic fill(input logic [15:0] seed, input bit uniform);
        for (int i = 0; i < 256; i++)
            img[i] = uniform ? seed : (16'(i) * 16'h9E37) ^ seed ^ 16'(i << 7);
    endtask

    task automatic seal(input int words);
        img[words-1][15:8] = model_crc(words);
    endtask

    task automatic break_short();
        img[SW-1][15:8] = model_crc(SW) ^ 8'h5A;
    endtask

    task automatic wait_done();
        for (int g = 0; g < 40000 && done_cnt == 0; g++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_chk();
        @(negedge clk); start_chk = 1'b1;
        @(negedge clk); start_chk = 1'b0;
    endtask

    task automatic run_check(input string tag, input int exp_long, input int exp_ok, input int exp_reads);
        logic [7:0] exp_rev;
        exp_rev = img[(exp_long != 0 ? LW : SW) - 1][7:0];
        clr_mon();
        pulse_chk();
        wait_done();
        chk({tag, " done pulses R12"}, done_cnt, 1);
        chk({tag, " done width R12"}, pulse_err, 0);
        chk({tag, " size_long"}, int'(size_long), exp_long);
        chk({tag, " crc_ok"}, int'(crc_ok), exp_ok);
        chk({tag, " read count"}, rd_cnt, exp_reads);
        chk({tag, " read order R7"}, rd_addr_err, 0);
        chk({tag, " revision R6"}, int'(revision), int'(exp_rev));
    endtask

    task automatic test_reset();
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 strobes", int'(mem_rd) + int'(mem_we) + int'(wr_enable), 0);
        chk("R1 results", int'(size_long) + int'(crc_ok) + int'(revision), 0);
    endtask

    task automatic test_model_anchor();
        chk("R2 model byte 0x01", int'(rev8(fwd_byte(8'h00, 8'h01))), 'hF7);
        chk("R2 model byte 0x80", int'(rev8(fwd_byte(8'h00, 8'h80))), 'hAB);
    endtask

    task automatic test_short_valid();
        fill(16'h3C5A, 1'b0); seal(SW);
        run_check("R3 R2 short valid", 0, 1, SW);
    endtask

    task automatic test_short_uniform();
        fill(16'hFFFF, 1'b1); seal(SW);
        run_check("R3 R2 uniform ones", 0, 1, SW);
    endtask

    task automatic test_long_valid();
        fill(16'h1234, 1'b0); break_short(); seal(LW);
        run_check("R4 long valid", 1, 1, SW + LW);
    endtask

    task automatic test_both_bad();
        fill(16'hA5C3, 1'b0); break_short(); seal(LW);
        img[LW-1][15:8] = img[LW-1][15:8] ^ 8'h01;
        run_check("R5 both corrupt", 1, 0, SW + LW);
    endtask

    task automatic test_write(input bit lng, input bit poke_chk);
        int n;
        int hold_l, hold_o, hold_r;
        n = lng ? LW : SW;
        hold_l = int'(size_long); hold_o = int'(crc_ok); hold_r = int'(revision);
        fill(lng ? 16'h0F0F : 16'h7711, 1'b0);
        for (int i = 0; i < 256; i++) wmem[i] = 16'hDEAD;
        clr_mon();
        @(negedge clk); start_wr = 1'b1; wr_long = lng;
        @(negedge clk); start_wr = 1'b0; wr_long = ~lng;
        if (poke_chk) begin
            repeat (SET + 30) @(negedge clk);
            pulse_chk();
        end
        wait_done();
        chk("R10 word count", wr_cnt, n);
        chk("R9 address order", addr_err, 0);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < n; i++) if (wmem[i] !== img[i]) bad++;
            chk("R9 data mismatches", bad, 0);
        end
        chk_win("R8 enable to first write", t_first - t_rise, SET);
        chk_win("R8 min write spacing", gap_min, GAP);
        chk_win("R8 max write spacing", gap_max, GAP);
        chk_win("R8 last write to enable drop", t_fall - t_last, GAP);
        chk_win("R8 enable drop to done", t_done - t_fall, SET);
        chk("R12 write done pulses", done_cnt, 1);
        if (poke_chk) begin
            chk("R11 no reads during write", rd_cnt, 0);
            chk("R11 results held", int'(size_long) * 512 + int'(crc_ok) * 256 + int'(revision),
                hold_l * 512 + hold_o * 256 + hold_r);
        end
    endtask

    task automatic test_wr_during_check();
        fill(16'h4242, 1'b0); seal(SW);
        clr_mon();
        pulse_chk();
        repeat (50) @(negedge clk);
        @(negedge clk); start_wr = 1'b1;
        @(negedge clk); start_wr = 1'b0;
        wait_done();
        chk("R11 no writes during check", wr_cnt, 0);
        chk("R11 enable stayed low", t_rise, 0);
        chk("R11 check result intact", int'(crc_ok), 1);
    endtask

    task automatic test_both_starts();
        fill(16'h5151, 1'b0); seal(SW);
        clr_mon();
        @(negedge clk); start_chk = 1'b1; start_wr = 1'b1;
        @(negedge clk); start_chk = 1'b0; start_wr = 1'b0;
        wait_done();
        chk("R12 both starts take check", rd_cnt, SW);
        chk("R12 both starts no write", wr_cnt, 0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog R12: actual timeout expected completion");
        summary();
    end

    initial begin
        fill(16'h0000, 1'b0);
        clr_mon();
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        test_reset();
        test_model_anchor();
        test_short_valid();
        test_short_uniform();
        test_long_valid();
        test_both_bad();
        test_write(1'b0, 1'b0);
        test_write(1'b1, 1'b1);
        test_wr_during_check();
        test_both_starts();
        summary();
    end

endmodule